// File: doc/BRIEF.md
# Mailbox Protocol-Checking State Machine

This block is the control core of a command mailbox shared by an on-chip microcontroller and agents on the system bus. It holds the lock, records who owns it, and steps a transaction through its phases: taking the lock, loading a command word, loading a length word, pushing data, handing execution to the receiver, and the receiver's reply. Bus agents reach it through a small register port that carries a user ID with every access. The microcontroller has its own control port for the same phases, for releasing the lock, and for programming the table of trusted user IDs.

The block checks the order of accesses from the bus side. An agent whose ID is in the trusted table and who holds the lock must follow the phase order. An agent with a trusted ID that writes anything but the status register while the bus side executes a command from the microcontroller also breaks the rules. Either violation parks the machine in an error state. The error state only fences off the bus side. It is left by a bus-side soft reset or by a microcontroller unlock. Accesses from untrusted IDs have no effect at all. Bus read data is registered and appears in the cycle after the read.

Top module: `mbx_proto_top`

## Requirements
- R1: After reset, state_code is 0 (idle), err_flag, uc_owns and status_done are 0, soc_rdata is 0, and every trusted-ID entry is disabled.
- R2: A bus read of the lock register (address 0) by a trusted ID while idle returns 0, grants the lock to that ID and moves to the command phase (code 1). A lock read while the mailbox is busy returns 1 and changes nothing.
- R3: The bus owner advances with a command write (address 1, moving to code 2), a length write (address 2, moving to code 3) and data writes (address 3, staying in code 3). An execute write (address 5) with bit 0 set moves to microcontroller execution (code 4). With bit 0 clear it has no effect. Reads of addresses 1, 2, 4 and 6 return the stored command, length, last data word and status. Address 7 returns the state code.
- R4: When the bus owner writes, in any phase from code 1 to code 3, a register other than the one that phase expects, the machine goes to the error state (code 7). Writing the length before the command is one such case.
- R5: Bus accesses from untrusted IDs change no state and read back 0. Writes from a trusted ID that does not own the lock are ignored in the data phases.
- R6: The trusted-ID table has 5 entries. Each entry holds an ID and an enable bit, is written through the configuration port, and matches only while its enable bit is set.
- R7: A microcontroller lock request while idle grants the lock to it (code 1, uc_owns = 1). It then advances through the phases with its own writes to the same addresses. No bus access can cause an error while it is in codes 1 to 3.
- R8: A microcontroller execute write with bit 0 set moves the machine to bus-side execution (code 5). There, a status write (address 6) from any trusted ID stores the status and sets status_done without leaving code 5. Any other write from any trusted ID goes to the error state.
- R9: In the error state err_flag is 1, bus writes are ignored and bus reads return 0.
- R10: soft_rst or uc_unlock returns the machine to idle from any state, with uc_owns and status_done cleared. Both take priority over every other input in the same cycle.
- R11: In microcontroller execution (code 4), a microcontroller write to address 6 stores a status word that appears on uc_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Bus-side soft reset, returns machine to idle |
| soc_req | input | 1 | Bus access strobe, one cycle per access |
| soc_wr | input | 1 | 1 = write, 0 = read |
| soc_addr | input | 3 | Register address |
| soc_wdata | input | DW | Bus write data |
| soc_user | input | UW | User ID of the accessing agent |
| soc_rdata | output | DW | Registered read data, valid the cycle after a read |
| uc_lock_req | input | 1 | Microcontroller lock request |
| uc_unlock | input | 1 | Microcontroller unlock, returns machine to idle |
| uc_wr | input | 1 | Microcontroller register write strobe |
| uc_addr | input | 3 | Microcontroller write address |
| uc_wdata | input | DW | Microcontroller write data |
| uc_cfg_we | input | 1 | Trusted-ID table write strobe |
| uc_cfg_idx | input | IW | Table entry index |
| uc_cfg_user | input | UW | ID to store in the entry |
| uc_cfg_vld | input | 1 | Enable bit to store in the entry |
| state_code | output | 3 | Current state code |
| err_flag | output | 1 | High while in the error state |
| uc_owns | output | 1 | Lock is held by the microcontroller |
| status_done | output | 1 | Bus side has written status during bus-side execution |
| uc_status | output | DW | Stored status word |

## Verification
Directed sequences drive a full bus-initiated transaction and a full microcontroller-initiated one. These show that correct ordering advances the phases and stores words that read back. Deliberate faults are then injected: a length write before the command, an execute clear during bus-side execution, and a lock read by an untrusted or disabled ID. These separate the two ways into the error state from accesses that must stay harmless. A constrained-random phase sends interleaved traffic from owners, trusted non-owners, untrusted IDs and the microcontroller. About half the addresses are biased toward the one the current phase expects, so that long legal runs mix with violations, unlocks and soft resets. Every output is compared against a bench model after every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CMD      = 3'd1,
    ST_DLEN     = 3'd2,
    ST_DATA     = 3'd3,
    ST_EXEC_UC  = 3'd4,
    ST_EXEC_SOC = 3'd5,
    ST_ERR      = 3'd7
  } mbx_state_e;

  localparam logic [2:0] A_LOCK    = 3'd0;
  localparam logic [2:0] A_CMD     = 3'd1;
  localparam logic [2:0] A_DLEN    = 3'd2;
  localparam logic [2:0] A_DATAIN  = 3'd3;
  localparam logic [2:0] A_DATAOUT = 3'd4;
  localparam logic [2:0] A_EXEC    = 3'd5;
  localparam logic [2:0] A_STATUS  = 3'd6;
  localparam logic [2:0] A_STATE   = 3'd7;

endpackage

// File: rtl/mbx_idfilter.sv
module mbx_idfilter #(
  parameter int NUM_IDS = 5,
  parameter int UW      = 8,
  parameter int IW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [UW-1:0] cfg_user,
  input  logic          cfg_vld,
  input  logic [UW-1:0] chk_user,
  output logic          hit
);

  logic [NUM_IDS-1:0] match;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_ent
    logic [UW-1:0] id_q;
    logic          en_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        id_q <= '0;
        en_q <= 1'b0;
      end else if (cfg_we && cfg_idx == IW'(i)) begin
        id_q <= cfg_user;
        en_q <= cfg_vld;
      end
    end

    assign match[i] = en_q && (id_q == chk_user);

    a_r6_disabled_no_match: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_idx == IW'(i) && !cfg_vld) |=> !match[i]);
  end

  assign hit = |match;

endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
  import mbx_pkg::*;
#(
  parameter int UW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          uc_unlock,
  input  logic          uc_lock_req,
  input  logic          uc_wr,
  input  logic [2:0]    uc_addr,
  input  logic          uc_bit0,
  input  logic          soc_req,
  input  logic          soc_wr,
  input  logic [2:0]    soc_addr,
  input  logic          soc_bit0,
  input  logic [UW-1:0] soc_user,
  input  logic          id_ok,
  output mbx_state_e    state_q,
  output logic          uc_own_q,
  output logic          err_q,
  output logic          acc_uc,
  output logic          acc_soc
);

  mbx_state_e    nxt;
  logic          nxt_uc;
  logic [UW-1:0] owner_q, nxt_owner;
  logic          soc_wr_ok, soc_rd_ok, own_hit, uc_any;

  assign soc_wr_ok = soc_req && soc_wr && id_ok;
  assign soc_rd_ok = soc_req && !soc_wr && id_ok;
  assign own_hit   = !uc_own_q && (soc_user == owner_q);
  assign uc_any    = soft_rst || uc_unlock || uc_lock_req || uc_wr;

  always_comb begin
    nxt       = state_q;
    nxt_uc    = uc_own_q;
    nxt_owner = owner_q;
    acc_uc    = 1'b0;
    acc_soc   = 1'b0;
    if (soft_rst || uc_unlock) begin
      nxt    = ST_IDLE;
      nxt_uc = 1'b0;
    end else if (uc_lock_req && state_q == ST_IDLE) begin
      nxt    = ST_CMD;
      nxt_uc = 1'b1;
    end else if (uc_wr && (uc_own_q || state_q == ST_EXEC_UC)) begin
      unique case (state_q)
        ST_CMD:  if (uc_addr == A_CMD)  begin acc_uc = 1'b1; nxt = ST_DLEN; end
        ST_DLEN: if (uc_addr == A_DLEN) begin acc_uc = 1'b1; nxt = ST_DATA; end
        ST_DATA: begin
          if (uc_addr == A_DATAIN) acc_uc = 1'b1;
          else if (uc_addr == A_EXEC && uc_bit0) nxt = ST_EXEC_SOC;
        end
        ST_EXEC_UC: if (uc_addr == A_STATUS) acc_uc = 1'b1;
        default: ;
      endcase
    end else if (soc_rd_ok && soc_addr == A_LOCK && state_q == ST_IDLE) begin
      nxt       = ST_CMD;
      nxt_uc    = 1'b0;
      nxt_owner = soc_user;
    end else if (soc_wr_ok) begin
      unique case (state_q)
        ST_CMD: if (own_hit) begin
          if (soc_addr == A_CMD) begin acc_soc = 1'b1; nxt = ST_DLEN; end
          else nxt = ST_ERR;
        end
        ST_DLEN: if (own_hit) begin
          if (soc_addr == A_DLEN) begin acc_soc = 1'b1; nxt = ST_DATA; end
          else nxt = ST_ERR;
        end
        ST_DATA: if (own_hit) begin
          if (soc_addr == A_DATAIN) acc_soc = 1'b1;
          else if (soc_addr == A_EXEC) begin
            if (soc_bit0) nxt = ST_EXEC_UC;
          end else nxt = ST_ERR;
        end
        ST_EXEC_SOC: begin
          if (soc_addr == A_STATUS) acc_soc = 1'b1;
          else nxt = ST_ERR;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      uc_own_q <= 1'b0;
      owner_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= nxt;
      uc_own_q <= nxt_uc;
      owner_q  <= nxt_owner;
      err_q    <= (nxt == ST_ERR);
    end
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERR && !soft_rst && !uc_unlock) |=> state_q == ST_ERR);

  a_r10_recover: assert property (@(posedge clk) disable iff (rst)
    (soft_rst || uc_unlock) |=> (state_q == ST_IDLE && !uc_own_q));

  a_r5_untrusted_quiet: assert property (@(posedge clk) disable iff (rst)
    (soc_req && !id_ok && !uc_any) |=> $stable(state_q));

  a_r7_uc_phase_safe: assert property (@(posedge clk) disable iff (rst)
    (uc_own_q && (state_q == ST_CMD || state_q == ST_DLEN || state_q == ST_DATA))
      |=> state_q != ST_ERR);

  a_r4_len_before_cmd: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CMD && !uc_own_q && soc_req && soc_wr && id_ok &&
     soc_user == owner_q && soc_addr == A_DLEN && !uc_any) |=> state_q == ST_ERR);

endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  mbx_state_e    state_q,
  input  logic          acc_uc,
  input  logic [2:0]    uc_addr,
  input  logic [DW-1:0] uc_wdata,
  input  logic          acc_soc,
  input  logic          soc_rd,
  input  logic          id_ok,
  input  logic [2:0]    soc_addr,
  input  logic [DW-1:0] soc_wdata,
  output logic [DW-1:0] soc_rdata,
  output logic [DW-1:0] status_q,
  output logic          done_q
);

  logic [DW-1:0] cmd_q, dlen_q, data_q;
  logic          wen;
  logic [2:0]    waddr;
  logic [DW-1:0] wdat;

  assign wen   = acc_uc || acc_soc;
  assign waddr = acc_uc ? uc_addr  : soc_addr;
  assign wdat  = acc_uc ? uc_wdata : soc_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      dlen_q   <= '0;
      data_q   <= '0;
      status_q <= '0;
    end else if (wen) begin
      unique case (waddr)
        A_CMD:    cmd_q    <= wdat;
        A_DLEN:   dlen_q   <= wdat;
        A_DATAIN: data_q   <= wdat;
        A_STATUS: status_q <= wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                              done_q <= 1'b0;
    else if (acc_soc && soc_addr == A_STATUS)    done_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soc_rdata <= '0;
    end else if (soc_rd && id_ok && state_q != ST_ERR) begin
      unique case (soc_addr)
        A_LOCK:    soc_rdata <= DW'(state_q != ST_IDLE);
        A_CMD:     soc_rdata <= cmd_q;
        A_DLEN:    soc_rdata <= dlen_q;
        A_DATAOUT: soc_rdata <= data_q;
        A_STATUS:  soc_rdata <= status_q;
        A_STATE:   soc_rdata <= DW'(state_q);
        default:   soc_rdata <= '0;
      endcase
    end else begin
      soc_rdata <= '0;
    end
  end

  a_r9_err_read_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERR && soc_rd) |=> soc_rdata == '0);

  a_r5_untrusted_read_zero: assert property (@(posedge clk) disable iff (rst)
    (soc_rd && !id_ok) |=> soc_rdata == '0);

endmodule

// File: rtl/mbx_proto_top.sv
module mbx_proto_top
  import mbx_pkg::*;
#(
  parameter  int DW      = 32,
  parameter  int UW      = 8,
  parameter  int NUM_IDS = 5,
  localparam int IW      = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          soc_req,
  input  logic          soc_wr,
  input  logic [2:0]    soc_addr,
  input  logic [DW-1:0] soc_wdata,
  input  logic [UW-1:0] soc_user,
  output logic [DW-1:0] soc_rdata,
  input  logic          uc_lock_req,
  input  logic          uc_unlock,
  input  logic          uc_wr,
  input  logic [2:0]    uc_addr,
  input  logic [DW-1:0] uc_wdata,
  input  logic          uc_cfg_we,
  input  logic [IW-1:0] uc_cfg_idx,
  input  logic [UW-1:0] uc_cfg_user,
  input  logic          uc_cfg_vld,
  output logic [2:0]    state_code,
  output logic          err_flag,
  output logic          uc_owns,
  output logic          status_done,
  output logic [DW-1:0] uc_status
);

  logic       id_ok, acc_uc, acc_soc;
  mbx_state_e state_q;

  mbx_idfilter #(.NUM_IDS(NUM_IDS), .UW(UW), .IW(IW)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (uc_cfg_we),
    .cfg_idx  (uc_cfg_idx),
    .cfg_user (uc_cfg_user),
    .cfg_vld  (uc_cfg_vld),
    .chk_user (soc_user),
    .hit      (id_ok)
  );

  mbx_fsm #(.UW(UW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .soft_rst    (soft_rst),
    .uc_unlock   (uc_unlock),
    .uc_lock_req (uc_lock_req),
    .uc_wr       (uc_wr),
    .uc_addr     (uc_addr),
    .uc_bit0     (uc_wdata[0]),
    .soc_req     (soc_req),
    .soc_wr      (soc_wr),
    .soc_addr    (soc_addr),
    .soc_bit0    (soc_wdata[0]),
    .soc_user    (soc_user),
    .id_ok       (id_ok),
    .state_q     (state_q),
    .uc_own_q    (uc_owns),
    .err_q       (err_flag),
    .acc_uc      (acc_uc),
    .acc_soc     (acc_soc)
  );

  mbx_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_rst || uc_unlock),
    .state_q   (state_q),
    .acc_uc    (acc_uc),
    .uc_addr   (uc_addr),
    .uc_wdata  (uc_wdata),
    .acc_soc   (acc_soc),
    .soc_rd    (soc_req && !soc_wr),
    .id_ok     (id_ok),
    .soc_addr  (soc_addr),
    .soc_wdata (soc_wdata),
    .soc_rdata (soc_rdata),
    .status_q  (uc_status),
    .done_q    (status_done)
  );

  assign state_code = state_q;

  a_r8_exec_soc_status_stays: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd5 && soc_req && soc_wr && soc_addr == 3'd6 &&
     !soft_rst && !uc_unlock) |=> state_code == 3'd5);

  a_r9_flag_tracks: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> state_code == 3'd7);

endmodule

// File: tb/tb_mbx_proto_top.sv
module tb_mbx_proto_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int UW = 8;
  localparam int NID = 5;
  localparam int IW = 3;

  logic clk = 0, rst = 1;
  logic soft_rst = 0, soc_req = 0, soc_wr = 0;
  logic [2:0] soc_addr = 0;
  logic [DW-1:0] soc_wdata = 0;
  logic [UW-1:0] soc_user = 0;
  logic [DW-1:0] soc_rdata;
  logic uc_lock_req = 0, uc_unlock = 0, uc_wr = 0;
  logic [2:0] uc_addr = 0;
  logic [DW-1:0] uc_wdata = 0;
  logic uc_cfg_we = 0, uc_cfg_vld = 0;
  logic [IW-1:0] uc_cfg_idx = 0;
  logic [UW-1:0] uc_cfg_user = 0;
  logic [2:0] state_code;
  logic err_flag, uc_owns, status_done;
  logic [DW-1:0] uc_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_proto_top #(.DW(DW), .UW(UW), .NUM_IDS(NID)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // bench model
  logic [2:0]    m_st = 0;
  logic          m_uc = 0, m_done = 0;
  logic [UW-1:0] m_owner = 0;
  logic [DW-1:0] m_cmd = 0, m_dlen = 0, m_data = 0, m_stat = 0;
  logic [UW-1:0] m_id [NID];
  logic          m_en [NID];
  logic [DW-1:0] e_rd;

  function automatic bit trusted(input logic [UW-1:0] u);
    for (int i = 0; i < NID; i++) if (m_en[i] && m_id[i] == u) return 1;
    return 0;
  endfunction

  function automatic logic [DW-1:0] read_val(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_st != 0);
      3'd1: return m_cmd;
      3'd2: return m_dlen;
      3'd4: return m_data;
      3'd6: return m_stat;
      3'd7: return DW'(m_st);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    bit ok = trusted(soc_user);
    bit rd = soc_req && !soc_wr;
    bit wr = soc_req && soc_wr;
    bit own = !m_uc && soc_user == m_owner;
    logic [2:0] ns = m_st;
    e_rd = (rd && ok && m_st != 7) ? read_val(soc_addr) : '0;
    if (soft_rst || uc_unlock) begin ns = 0; m_uc = 0; m_done = 0; end
    else if (uc_lock_req && m_st == 0) begin ns = 1; m_uc = 1; end
    else if (uc_wr && (m_uc || m_st == 4)) begin
      case (m_st)
        1: if (uc_addr == 1) begin m_cmd = uc_wdata; ns = 2; end
        2: if (uc_addr == 2) begin m_dlen = uc_wdata; ns = 3; end
        3: if (uc_addr == 3) m_data = uc_wdata;
           else if (uc_addr == 5 && uc_wdata[0]) ns = 5;
        4: if (uc_addr == 6) m_stat = uc_wdata;
        default: ;
      endcase
    end else if (rd && ok && soc_addr == 0 && m_st == 0) begin
      ns = 1; m_uc = 0; m_owner = soc_user;
    end else if (wr && ok) begin
      case (m_st)
        1: if (own) begin if (soc_addr == 1) begin m_cmd = soc_wdata; ns = 2; end else ns = 7; end
        2: if (own) begin if (soc_addr == 2) begin m_dlen = soc_wdata; ns = 3; end else ns = 7; end
        3: if (own) begin
             if (soc_addr == 3) m_data = soc_wdata;
             else if (soc_addr == 5) begin if (soc_wdata[0]) ns = 4; end
             else ns = 7;
           end
        5: if (soc_addr == 6) begin m_stat = soc_wdata; m_done = 1; end else ns = 7;
        default: ;
      endcase
    end
    if (uc_cfg_we && uc_cfg_idx < NID) begin
      m_id[uc_cfg_idx] = uc_cfg_user; m_en[uc_cfg_idx] = uc_cfg_vld;
    end
    m_st = ns;
  endtask

  task automatic step(input string tag);
    model_step();
    @(negedge clk);
    check({tag, " state"}, DW'(state_code), DW'(m_st));
    check({tag, " err"}, DW'(err_flag), DW'(m_st == 7));
    check({tag, " owns"}, DW'(uc_owns), DW'(m_uc));
    check({tag, " done"}, DW'(status_done), DW'(m_done));
    check({tag, " status"}, uc_status, m_stat);
    check({tag, " rdata"}, soc_rdata, e_rd);
    soc_req = 0; soc_wr = 0; uc_lock_req = 0; uc_unlock = 0; uc_wr = 0;
    uc_cfg_we = 0; soft_rst = 0;
  endtask

  task automatic soc(input bit w, input logic [2:0] a, input logic [DW-1:0] d,
                     input logic [UW-1:0] u, input string tag);
    soc_req = 1; soc_wr = w; soc_addr = a; soc_wdata = d; soc_user = u;
    step(tag);
  endtask

  task automatic ucw(input logic [2:0] a, input logic [DW-1:0] d, input string tag);
    uc_wr = 1; uc_addr = a; uc_wdata = d; step(tag);
  endtask

  task automatic cfg(input int idx, input logic [UW-1:0] u, input bit v, input string tag);
    uc_cfg_we = 1; uc_cfg_idx = IW'(idx); uc_cfg_user = u; uc_cfg_vld = v; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [UW-1:0] pool [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    void'($urandom(32'd4242));
    for (int i = 0; i < NID; i++) begin m_id[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    e_rd = 0;
    // R1 reset state
    check("R1 state", DW'(state_code), 0);
    check("R1 err", DW'(err_flag), 0);
    check("R1 owns", DW'(uc_owns), 0);
    check("R1 rdata", soc_rdata, 0);
    soc(0, 3'd0, 0, 8'h11, "R1 no entry enabled");
    // R6 table programming
    cfg(0, 8'h11, 1, "R6 cfg0");
    cfg(1, 8'h22, 1, "R6 cfg1");
    cfg(2, 8'h33, 0, "R6 cfg2 disabled");
    cfg(3, 8'h44, 1, "R6 cfg3");
    cfg(3, 8'h44, 0, "R6 cfg3 disable");
    soc(0, 3'd0, 0, 8'h33, "R6 disabled id lock");
    soc(0, 3'd0, 0, 8'h44, "R5 untrusted lock");
    // R2 lock
    soc(0, 3'd0, 0, 8'h11, "R2 grant");
    soc(0, 3'd0, 0, 8'h22, "R2 busy");
    soc(1, 3'd2, 5, 8'h22, "R5 non-owner write");
    soc(1, 3'd2, 5, 8'h11, "R4 len before cmd");
    soc(0, 3'd1, 0, 8'h11, "R9 read zero");
    soc(1, 3'd1, 9, 8'h11, "R9 write ignored");
    uc_unlock = 1; step("R10 unlock from error");
    // R3 bus-initiated flow
    soc(0, 3'd0, 0, 8'h11, "R3 lock");
    soc(1, 3'd1, 32'hA5, 8'h11, "R3 cmd");
    soc(1, 3'd2, 8, 8'h11, "R3 len");
    soc(1, 3'd3, 32'h1234, 8'h11, "R3 data");
    soc(0, 3'd1, 0, 8'h22, "R3 cmd readback");
    soc(0, 3'd4, 0, 8'h11, "R3 data readback");
    soc(1, 3'd5, 0, 8'h11, "R3 exec clear no effect");
    soc(1, 3'd5, 1, 8'h11, "R3 exec");
    soc(0, 3'd7, 0, 8'h11, "R3 state read");
    ucw(3'd6, 32'h77, "R11 uc status");
    uc_unlock = 1; step("R10 unlock");
    // R7/R8 microcontroller-initiated flow
    uc_lock_req = 1; step("R7 uc lock");
    soc(1, 3'd2, 3, 8'h11, "R7 bus write no error");
    ucw(3'd1, 32'hC3, "R7 uc cmd");
    ucw(3'd2, 4, "R7 uc len");
    ucw(3'd3, 32'hBEEF, "R7 uc data");
    ucw(3'd5, 1, "R8 uc exec");
    soc(0, 3'd4, 0, 8'h22, "R8 dataout");
    soc(1, 3'd6, 5, 8'h22, "R8 status write");
    soc(1, 3'd5, 0, 8'h11, "R8 exec clear error");
    soft_rst = 1; step("R10 soft reset");
    soft_rst = 1; soc_req = 1; soc_wr = 0; soc_addr = 0; soc_user = 8'h11;
    step("R10 soft reset priority");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic [2:0] a = 3'($urandom);
      if ($urandom_range(0, 1)) begin
        case (m_st)
          0: a = 0; 1: a = 1; 2: a = 2; 3: a = ($urandom_range(0, 3) == 0) ? 3'd5 : 3'd3;
          default: a = 6;
        endcase
      end
      if (r < 3)       begin soft_rst = 1; step("random"); end
      else if (r < 7)  begin uc_unlock = 1; step("random"); end
      else if (r < 12) begin uc_lock_req = 1; step("random"); end
      else if (r < 25) ucw(a, DW'($urandom_range(0, 3)), "random");
      else if (r < 27) cfg($urandom_range(0, NID - 1), pool[$urandom_range(0, 5)],
                           $urandom_range(0, 1) == 1, "random");
      else soc($urandom_range(0, 1) == 1, a, DW'($urandom),
               ($urandom_range(0, 3) == 0) ? pool[$urandom_range(0, 5)] : m_owner, "random");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule